// File: doc/BRIEF.md
# Receive Clock Gating Controller

This block lowers receive-path power by stopping the receive clock while no frame arrives. It sits on the free-running receive clock and passes the receive data and its valid flag through one register stage. The undelayed valid flag therefore acts as an early warning, and the clock can be turned back on before the delayed valid flag reaches downstream logic. When a frame ends, the clock keeps running for a fixed tail of cycles before it is stopped again.

Gating applies only when the software enable is set and the link runs at 100 Mb/s. Loopback or the code-group bypass mode each force the clock to run continuously. The gating cell itself lies outside this block. The block drives its enable, `clk_en`, which changes only while the receive clock is low, so the gated clock `clk & clk_en` has no runt pulses.

Top module: `rxclk_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `rx_dv_out` is 0, `rx_data_out` is all zeros and `clk_en` is 1.
- R2: `rx_data_out` and `rx_dv_out` equal the `rx_data_in` and `rx_dv_in` values captured one rising edge earlier.
- R3: If `gate_en` is 0 or `mode_100` is 0, `clk_en` stays 1 in every cycle.
- R4: While `loopback` is 1, `clk_en` stays 1 regardless of the other inputs.
- R5: While `bypass` is 1, `clk_en` stays 1 regardless of the other inputs.
- R6: With gating active, `rx_dv_in` and `rx_dv_out` both 0, and the tail expired, `clk_en` is 0 in the low phase of that cycle.
- R7: In the low phase of the cycle in which `rx_dv_in` is first 1, `clk_en` is already 1. The first gated rising edge is thus the edge that launches `rx_dv_out` high, one cycle before any edge samples it high.
- R8: After the rising edge at which `rx_dv_out` falls, `clk_en` stays 1 for exactly TAIL_CYC (default 64) gated rising edges and then drops to 0, unless R9 applies.
- R9: If `rx_dv_in` returns to 1 before the tail expires, `clk_en` stays 1 without any low cycle, and a fresh full tail begins after the next fall of `rx_dv_out`.
- R10: `clk_en` changes value only while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Software enable for clock gating |
| mode_100 | input | 1 | Link operates at 100 Mb/s |
| loopback | input | 1 | Loopback active; forces the clock on |
| bypass | input | 1 | Code-group bypass active; forces the clock on |
| rx_dv_in | input | 1 | Undelayed receive data-valid |
| rx_data_in | input | DATA_W | Undelayed receive data |
| rx_dv_out | output | 1 | Data-valid delayed by one cycle |
| rx_data_out | output | DATA_W | Data delayed by one cycle |
| clk_en | output | 1 | Enable for the external clock-gating cell |

## Verification
The tail expiry and a new wake-up can fall in the same cycle. The tail counter reaches zero on the same edge at which a fresh `rx_dv_in` appears, so the enable must not dip low even for the one cycle in which both events coincide. The bench provokes this with frame gaps placed around the tail length (62 to 66 idle cycles) and with random gaps, some shorter and some longer. It judges every cycle in the low phase against an enable predicted from the time elapsed since `rx_dv_out` last fell.

// File: rtl/rxcg_pkg.sv
package rxcg_pkg;

   typedef struct packed {
      logic gate_en;
      logic mode_100;
      logic loopback;
      logic bypass;
   } rxcg_mode_t;

   // gating may stop the clock only in this combination of mode bits
   function automatic logic rxcg_gating_ok(input rxcg_mode_t m);
      return m.gate_en & m.mode_100 & ~m.loopback & ~m.bypass;
   endfunction

endpackage

// File: rtl/rxcg_delay.sv
module rxcg_delay #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dv_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              dv_q,
   output logic [DATA_W-1:0] data_q
);

   if (DATA_W < 1) begin : g_bad_width
      $error("rxcg_delay: DATA_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q   <= 1'b0;
         data_q <= '0;
      end else begin
         dv_q   <= dv_in;
         data_q <= data_in;
      end
   end

   a_r2_dv_delay : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dv_q == $past(dv_in)));

endmodule

// File: rtl/rxcg_tail.sv
module rxcg_tail #(
   parameter int TAIL_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dv_q,
   output logic busy
);

   if (TAIL_CYC < 0) begin : g_bad_tail
      $error("rxcg_tail: TAIL_CYC must not be negative");
   end

   if (TAIL_CYC > 0) begin : g_count
      localparam int CNT_W = $clog2(TAIL_CYC + 1);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(TAIL_CYC);

      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (dv_q)
            cnt <= LOAD;
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end

      assign busy = (cnt != '0);

      a_r8_reload : assert property (@(posedge clk) disable iff (!rst_n)
         dv_q |=> (cnt == LOAD));
      a_r8_countdown : assert property (@(posedge clk) disable iff (!rst_n)
         (!dv_q && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
      a_r8_bound : assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LOAD);
   end else begin : g_no_tail
      assign busy = 1'b0;
   end

endmodule

// File: rtl/rxcg_hold.sv
module rxcg_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   output logic en
);

   // captured on the falling edge, so the enable is stable across the high phase
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         en <= 1'b1;
      else
         en <= want;
   end

   always @(en) begin
      if (rst_n) begin
         a_r10_low_phase : assert (!clk);
      end
   end

endmodule

// File: rtl/rxclk_gate_ctrl.sv
module rxclk_gate_ctrl #(
   parameter int DATA_W   = 4,
   parameter int TAIL_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_en,
   input  logic              mode_100,
   input  logic              loopback,
   input  logic              bypass,
   input  logic              rx_dv_in,
   input  logic [DATA_W-1:0] rx_data_in,
   output logic              rx_dv_out,
   output logic [DATA_W-1:0] rx_data_out,
   output logic              clk_en
);

   import rxcg_pkg::*;

   if (DATA_W < 1 || TAIL_CYC < 0) begin : g_bad_params
      $error("rxclk_gate_ctrl: illegal parameter values");
   end

   rxcg_mode_t mode;
   logic       gating_ok;
   logic       tail_busy;
   logic       want_clk;

   assign mode      = '{gate_en: gate_en, mode_100: mode_100,
                        loopback: loopback, bypass: bypass};
   assign gating_ok = rxcg_gating_ok(mode);

   rxcg_delay #(.DATA_W(DATA_W)) u_delay (
      .clk     (clk),
      .rst_n   (rst_n),
      .dv_in   (rx_dv_in),
      .data_in (rx_data_in),
      .dv_q    (rx_dv_out),
      .data_q  (rx_data_out)
   );

   rxcg_tail #(.TAIL_CYC(TAIL_CYC)) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .dv_q  (rx_dv_out),
      .busy  (tail_busy)
   );

   // the undelayed valid flag is the early wake-up
   assign want_clk = ~gating_ok | rx_dv_in | rx_dv_out | tail_busy;

   rxcg_hold u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want_clk),
      .en    (clk_en)
   );

   a_r3_no_gate_off : assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en || !mode_100) |-> clk_en);
   a_r4_loopback_on : assert property (@(posedge clk) disable iff (!rst_n)
      loopback |-> clk_en);
   a_r5_bypass_on : assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> clk_en);
   a_r7_early_wake : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv_out) |-> ($past(clk_en) && clk_en));
   a_r9_on_with_valid : assert property (@(posedge clk) disable iff (!rst_n)
      rx_dv_out |-> clk_en);

endmodule

// File: tb/sim_rxclk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_rxclk_gate_ctrl;

   localparam int DW   = 4;
   localparam int TAIL = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          gate_en = 1'b0, mode_100 = 1'b0, loopback = 1'b0, bypass = 1'b0;
   logic          rx_dv_in = 1'b0;
   logic [DW-1:0] rx_data_in = '0;
   logic          rx_dv_out;
   logic [DW-1:0] rx_data_out;
   logic          clk_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model state
   logic          m_dv = 1'b0;
   logic [DW-1:0] m_data = '0;
   int            m_since = 1000;

   always #5 clk = ~clk;

   rxclk_gate_ctrl #(.DATA_W(DW), .TAIL_CYC(TAIL)) u0 (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .mode_100(mode_100),
      .loopback(loopback), .bypass(bypass), .rx_dv_in(rx_dv_in),
      .rx_data_in(rx_data_in), .rx_dv_out(rx_dv_out),
      .rx_data_out(rx_data_out), .clk_en(clk_en)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // R10: enable must only move in the low phase
   always @(clk_en) begin
      if (rst_n && $time > 0) check("R10 enable edge in low phase", clk, 0);
   end

   function automatic string en_tag(input logic [3:0] md, input logic dv);
      if (md[0]) return "R5 bypass forces clock";
      if (md[1]) return "R4 loopback forces clock";
      if (!md[3] || !md[2]) return "R3 gating disabled";
      if (dv && !m_dv) return "R7 early wake";
      if (m_since < TAIL && dv) return "R9 reassert in tail";
      if (m_since < TAIL || m_dv) return "R8 tail hold";
      return "R6 idle gated off";
   endfunction

   function automatic int exp_en(input logic [3:0] md, input logic dv);
      logic act;
      act = md[3] & md[2] & ~md[1] & ~md[0];
      return int'(!act || dv || m_dv || (m_since < TAIL));
   endfunction

   // md = {gate_en, mode_100, loopback, bypass}
   task automatic cyc(input logic [3:0] md, input logic dv, input logic [DW-1:0] d);
      @(posedge clk);
      if (m_dv) m_since = 0;
      else if (m_since < 1000) m_since++;
      m_dv   = rx_dv_in;
      m_data = rx_data_in;
      #1;
      {gate_en, mode_100, loopback, bypass} = md;
      rx_dv_in   = dv;
      rx_data_in = d;
      #5;
      check("R2 dv delay", int'(rx_dv_out), int'(m_dv));
      check("R2 data delay", int'(rx_data_out), int'(m_data));
      check(en_tag(md, dv), int'(clk_en), exp_en(md, dv));
   endtask

   task automatic frame(input logic [3:0] md, input int len, input int gap);
      for (int i = 0; i < len; i++) cyc(md, 1'b1, DW'($urandom));
      for (int i = 0; i < gap; i++) cyc(md, 1'b0, DW'($urandom));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd1234);
      rx_data_in = 4'hA;
      rx_dv_in   = 1'b1;
      #23;
      // R1 reset state while inputs toggle
      check("R1 reset dv", int'(rx_dv_out), 0);
      check("R1 reset data", int'(rx_data_out), 0);
      check("R1 reset enable", int'(clk_en), 1);
      rx_dv_in = 1'b0;
      rx_data_in = '0;
      @(posedge clk);
      #1 rst_n = 1'b1;

      // R3: gating disabled or 10 Mb/s
      frame(4'b0000, 3, 80);
      frame(4'b1000, 3, 80);
      frame(4'b0100, 3, 80);
      // R6/R7/R8 basic gated run
      frame(4'b1100, 5, 100);
      // R4 / R5
      frame(4'b1110, 4, 90);
      frame(4'b1101, 4, 90);
      frame(4'b1100, 1, 70);
      // corner gaps around the tail length (R8, R9)
      for (int g = 62; g <= 66; g++) frame(4'b1100, 2, g);
      frame(4'b1100, 3, 1);
      frame(4'b1100, 3, 0);
      frame(4'b1100, 3, 100);
      // constrained random
      for (int k = 0; k < 150; k++) begin
         logic [3:0] md;
         int r;
         r  = int'($urandom_range(0, 9));
         md = (r < 6) ? 4'b1100 : 4'($urandom);
         frame(md, int'($urandom_range(1, 20)), int'($urandom_range(0, 110)));
      end
      frame(4'b1100, 0, 80);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule